// File: doc/BRIEF.md
# Two-Channel Acquisition Decimator with Min/Max Reduction

The block takes the word stream of a dual-channel converter that runs at a fixed rate and delivers both channels on one shared bus. It produces a slower stream of reduced samples written into a per-channel capture memory. A channel flag marks each bus word. An A word is held, and the B word that follows completes a sample pair. Each pair is then reduced per channel in one of three ways, picked at the start of an acquisition:

- decimate: keep the first pair of each group of N;
- average: the truncated mean of N pairs;
- min/max: over 2N pairs, emit the minimum and then the maximum as two consecutive memory entries.

The min/max mode therefore stores extreme pairs at half the group rate of the other modes. N is a power of two given as its base-2 logarithm, so the mean is a right shift of the sum. The recorded rate is the converter rate divided by N.

An acquisition starts with a one-cycle start pulse. The pulse latches the configuration, clears the group counter, the accumulators and the write address, and drops any group in progress. After that, reduction runs without stopping. Writes go to a circular address range the size of the capture memory.

Top module: `acq_decim`

## Requirements
- R1: After reset, wr_en is 0 and wr_addr is 0.
- R2: A word with adc_chan=0 is the A sample and is held. The latest held A sample forms a pair with the next word that has adc_chan=1 (the B sample). A run of A words with no B word in between produces no pair.
- R3: In decimate mode (cfg_mode=0), each group of 2^cfg_log2n pairs gives one write with wr_kind=0, and its data is the first pair of the group.
- R4: In average mode (cfg_mode=1), each group of 2^cfg_log2n pairs gives one write with wr_kind=0. Per channel, its data is floor(sum / 2^cfg_log2n), and this holds without overflow when every sample is 0x3FFF.
- R5: In min/max mode (cfg_mode=2), each group of 2^(cfg_log2n+1) pairs gives two writes on consecutive cycles. The first write has wr_kind=0 and holds the per-channel minimum. The second has wr_kind=1 and holds the per-channel maximum.
- R6: With cfg_log2n=0, decimate and average pass every pair through unchanged. Min/max writes every two pairs.
- R7: The pair whose A word arrives together with acq_start is the first pair of a group. The start pulse drops any partial group, and no write comes from it.
- R8: wr_addr is 0 for the first write after a start and rises by one per write, wrapping modulo DEPTH (8192 by default).
- R9: The write for a group asserts wr_en during the cycle after the third rising edge counted from the edge that samples the group's closing B word. It is low during the cycle before that edge.
- R10: cfg_mode=3 acts as decimate. A cfg_log2n above MAX_LOG2N (8) acts as MAX_LOG2N.
- R11: No write occurs after reset until the first acq_start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter data clock |
| rst_n | input | 1 | Synchronous active-low reset |
| adc_data | input | 14 | Shared converter data bus |
| adc_chan | input | 1 | Channel flag of the bus word: 0 = A, 1 = B |
| acq_start | input | 1 | One-cycle acquisition start; latches the configuration |
| cfg_mode | input | 2 | Reduction: 0 decimate, 1 average, 2 min/max, 3 decimate |
| cfg_log2n | input | 4 | Base-2 logarithm of N |
| wr_en | output | 1 | Memory write strobe |
| wr_kind | output | 1 | 1 when the entry is a min/max maximum, else 0 |
| wr_addr | output | 13 | Memory write address |
| wr_data_a | output | 14 | Reduced channel A value |
| wr_data_b | output | 14 | Reduced channel B value |

## Verification
A group counter that is off by one shows at the ports within the first group after a start. A write arrives one pair early or late, its decimated value comes from the wrong pair, and the address sequence loses step with the expected entry list. A corrupt accumulator or extreme register shows as wrong data on the very write that closes the affected group. An error on the start path shows as a nonzero first address, or as a stray write out of a dropped partial group, within three cycles of the group boundary.

// File: rtl/acq_decim_pkg.sv
// Shared types for the acquisition decimator.
// Assumes a two-bit mode field; code 3 is folded onto decimate by the controller.
package acq_decim_pkg;
    typedef enum logic [1:0] {
        RED_DEC    = 2'd0,
        RED_AVG    = 2'd1,
        RED_MINMAX = 2'd2
    } red_mode_t;
endpackage

// File: rtl/acq_demux.sv
// Splits the shared converter bus into sample pairs.
// Holds the most recent A word; a B word closes a pair, which is presented
// for one cycle after the edge that samples the B word.
module acq_demux #(
    parameter int DATA_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              bus_chan,
    output logic              pair_valid,
    output logic [DATA_W-1:0] pair_a,
    output logic [DATA_W-1:0] pair_b
);
    logic [DATA_W-1:0] a_hold;

    // Hold the latest A word and register a pair when a B word arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_hold     <= '0;
            pair_valid <= 1'b0;
            pair_a     <= '0;
            pair_b     <= '0;
        end else begin
            pair_valid <= bus_chan;
            if (!bus_chan) begin
                a_hold <= bus_data;
            end else begin
                pair_a <= a_hold;
                pair_b <= bus_data;
            end
        end
    end
endmodule

// File: rtl/acq_ctrl.sv
// Acquisition controller: latches the configuration on start and counts
// pairs within a reduction group. Pairs present in the start cycle are
// dropped; the pair whose A word comes with the start opens the first group.
module acq_ctrl
    import acq_decim_pkg::*;
#(
    parameter int MAX_LOG2N = 8,
    parameter int SH_W      = $clog2(MAX_LOG2N + 1),
    parameter int CNT_W     = MAX_LOG2N + 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [1:0]      cfg_mode,
    input  logic [SH_W-1:0] cfg_log2n,
    input  logic            pair_valid,
    output logic            step,
    output logic            grp_first,
    output logic            grp_last,
    output red_mode_t       mode_q,
    output logic [SH_W-1:0] shift_q
);
    logic             active;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_last;

    // Latch the mode and the clamped shift, and arm the acquisition on start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            mode_q  <= RED_DEC;
            shift_q <= '0;
        end else if (start) begin
            active  <= 1'b1;
            mode_q  <= (cfg_mode == 2'd3) ? RED_DEC : red_mode_t'(cfg_mode);
            shift_q <= (cfg_log2n > SH_W'(MAX_LOG2N)) ? SH_W'(MAX_LOG2N) : cfg_log2n;
        end
    end

    // Index of the last pair in a group: 2N-1 for min/max, N-1 otherwise.
    always_comb begin
        if (mode_q == RED_MINMAX) begin
            cnt_last = (CNT_W'(2) << shift_q) - CNT_W'(1);
        end else begin
            cnt_last = (CNT_W'(1) << shift_q) - CNT_W'(1);
        end
    end

    assign step      = pair_valid && active && !start;
    assign grp_first = (cnt == '0);
    assign grp_last  = (cnt == cnt_last);

    // Count pairs in the group; restart at the group end and on start.
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= grp_last ? '0 : cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/acq_reduce.sv
// Per-channel reducer: keeps the first sample, a running sum and running
// extremes across a group, and presents the results for one cycle after
// the group's last pair. Assumes unsigned samples and a shift of at most
// MAX_LOG2N, so the sum never exceeds ACC_W bits.
module acq_reduce
    import acq_decim_pkg::*;
#(
    parameter int DATA_W    = 14,
    parameter int MAX_LOG2N = 8,
    parameter int SH_W      = $clog2(MAX_LOG2N + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              grp_first,
    input  logic              grp_last,
    input  red_mode_t         mode,
    input  logic [SH_W-1:0]   shift,
    input  logic [DATA_W-1:0] sample,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_main,
    output logic [DATA_W-1:0] out_min,
    output logic [DATA_W-1:0] out_max
);
    localparam int ACC_W = DATA_W + MAX_LOG2N;

    logic [ACC_W-1:0]  acc, acc_nx;
    logic [DATA_W-1:0] first_q, first_nx;
    logic [DATA_W-1:0] mn_q, mn_nx;
    logic [DATA_W-1:0] mx_q, mx_nx;

    // Next values of the group state, each restarted by the first pair.
    always_comb begin
        if (grp_first) begin
            acc_nx   = ACC_W'(sample);
            first_nx = sample;
            mn_nx    = sample;
            mx_nx    = sample;
        end else begin
            acc_nx   = acc + ACC_W'(sample);
            first_nx = first_q;
            mn_nx    = (sample < mn_q) ? sample : mn_q;
            mx_nx    = (sample > mx_q) ? sample : mx_q;
        end
    end

    // Update the group state on each accepted pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc     <= '0;
            first_q <= '0;
            mn_q    <= '0;
            mx_q    <= '0;
        end else if (step) begin
            acc     <= acc_nx;
            first_q <= first_nx;
            mn_q    <= mn_nx;
            mx_q    <= mx_nx;
        end
    end

    // Register the group result when its last pair is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_main  <= '0;
            out_min   <= '0;
            out_max   <= '0;
        end else begin
            out_valid <= step && grp_last;
            if (step && grp_last) begin
                out_main <= (mode == RED_AVG) ? DATA_W'(acc_nx >> shift) : first_nx;
                out_min  <= mn_nx;
                out_max  <= mx_nx;
            end
        end
    end
endmodule

// File: rtl/acq_writer.sv
// Memory write sequencer: turns each group result into one write, or into a
// minimum write followed by a maximum write in min/max mode. The address
// starts at zero on start and wraps at the memory depth. Assumes results
// arrive at least two cycles apart.
module acq_writer
    import acq_decim_pkg::*;
#(
    parameter int DATA_W = 14,
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  red_mode_t         mode,
    input  logic              res_valid,
    input  logic [DATA_W-1:0] res_main_a,
    input  logic [DATA_W-1:0] res_main_b,
    input  logic [DATA_W-1:0] res_min_a,
    input  logic [DATA_W-1:0] res_min_b,
    input  logic [DATA_W-1:0] res_max_a,
    input  logic [DATA_W-1:0] res_max_b,
    output logic              wr_en,
    output logic              wr_kind,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data_a,
    output logic [DATA_W-1:0] wr_data_b
);
    logic              max_pend;
    logic [DATA_W-1:0] max_a_q, max_b_q;

    // Issue writes and step the address after every write.
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            wr_en     <= 1'b0;
            wr_kind   <= 1'b0;
            wr_addr   <= '0;
            wr_data_a <= '0;
            wr_data_b <= '0;
            max_pend  <= 1'b0;
            max_a_q   <= '0;
            max_b_q   <= '0;
        end else begin
            wr_addr <= wr_addr + ADDR_W'(wr_en);
            if (res_valid) begin
                wr_en    <= 1'b1;
                wr_kind  <= 1'b0;
                max_pend <= (mode == RED_MINMAX);
                max_a_q  <= res_max_a;
                max_b_q  <= res_max_b;
                if (mode == RED_MINMAX) begin
                    wr_data_a <= res_min_a;
                    wr_data_b <= res_min_b;
                end else begin
                    wr_data_a <= res_main_a;
                    wr_data_b <= res_main_b;
                end
            end else if (max_pend) begin
                wr_en     <= 1'b1;
                wr_kind   <= 1'b1;
                max_pend  <= 1'b0;
                wr_data_a <= max_a_q;
                wr_data_b <= max_b_q;
            end else begin
                wr_en   <= 1'b0;
                wr_kind <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/acq_decim.sv
// Top level of the two-channel acquisition decimator: bus demux, group
// control, one reducer per channel, and the memory write sequencer.
// Assumes the bus alternates A and B words; the start pulse goes with an A word.
module acq_decim
    import acq_decim_pkg::*;
#(
    parameter int DATA_W    = 14,
    parameter int MAX_LOG2N = 8,
    parameter int DEPTH     = 8192
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [DATA_W-1:0]                    adc_data,
    input  logic                                 adc_chan,
    input  logic                                 acq_start,
    input  logic [1:0]                           cfg_mode,
    input  logic [$clog2(MAX_LOG2N + 1)-1:0]     cfg_log2n,
    output logic                                 wr_en,
    output logic                                 wr_kind,
    output logic [$clog2(DEPTH)-1:0]             wr_addr,
    output logic [DATA_W-1:0]                    wr_data_a,
    output logic [DATA_W-1:0]                    wr_data_b
);
    localparam int SH_W   = $clog2(MAX_LOG2N + 1);
    localparam int ADDR_W = $clog2(DEPTH);
    localparam int N_CH   = 2;

    logic              pair_valid;
    logic [DATA_W-1:0] pair_s [N_CH];
    logic              step, grp_first, grp_last;
    red_mode_t         mode_q;
    logic [SH_W-1:0]   shift_q;
    logic              res_valid [N_CH];
    logic [DATA_W-1:0] res_main [N_CH];
    logic [DATA_W-1:0] res_min  [N_CH];
    logic [DATA_W-1:0] res_max  [N_CH];

    acq_demux #(.DATA_W(DATA_W)) u_demux (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_data   (adc_data),
        .bus_chan   (adc_chan),
        .pair_valid (pair_valid),
        .pair_a     (pair_s[0]),
        .pair_b     (pair_s[1])
    );

    acq_ctrl #(.MAX_LOG2N(MAX_LOG2N)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (acq_start),
        .cfg_mode   (cfg_mode),
        .cfg_log2n  (cfg_log2n),
        .pair_valid (pair_valid),
        .step       (step),
        .grp_first  (grp_first),
        .grp_last   (grp_last),
        .mode_q     (mode_q),
        .shift_q    (shift_q)
    );

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_chan
        acq_reduce #(.DATA_W(DATA_W), .MAX_LOG2N(MAX_LOG2N)) u_reduce (
            .clk       (clk),
            .rst_n     (rst_n),
            .step      (step),
            .grp_first (grp_first),
            .grp_last  (grp_last),
            .mode      (mode_q),
            .shift     (shift_q),
            .sample    (pair_s[ch]),
            .out_valid (res_valid[ch]),
            .out_main  (res_main[ch]),
            .out_min   (res_min[ch]),
            .out_max   (res_max[ch])
        );
    end

    acq_writer #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_writer (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (acq_start),
        .mode       (mode_q),
        .res_valid  (res_valid[0] && res_valid[1]),
        .res_main_a (res_main[0]),
        .res_main_b (res_main[1]),
        .res_min_a  (res_min[0]),
        .res_min_b  (res_min[1]),
        .res_max_a  (res_max[0]),
        .res_max_b  (res_max[1]),
        .wr_en      (wr_en),
        .wr_kind    (wr_kind),
        .wr_addr    (wr_addr),
        .wr_data_a  (wr_data_a),
        .wr_data_b  (wr_data_b)
    );
endmodule

// File: rtl/acq_decim_chk.sv
// Checker for the decimator's write port, bound to every acq_decim instance.
// Relates the start pulse, the address sequence and min/max write ordering.
module acq_decim_chk #(
    parameter int DATA_W = 14,
    parameter int ADDR_W = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acq_start,
    input logic              wr_en,
    input logic              wr_kind,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data_a,
    input logic [DATA_W-1:0] wr_data_b
);
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        acq_start |=> (!wr_en && wr_addr == '0));                               // R7
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !acq_start) |=> (wr_addr == $past(wr_addr) + 1'b1));          // R8
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !acq_start) |=> $stable(wr_addr));                           // R8
    AST_MAX_AFTER_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_kind) |-> $past(wr_en && !wr_kind));                       // R5
    AST_MAX_NOT_BELOW_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_kind) |-> (wr_data_a >= $past(wr_data_a)
                                && wr_data_b >= $past(wr_data_b)));             // R5
endmodule

bind acq_decim acq_decim_chk #(.DATA_W(DATA_W), .ADDR_W($clog2(DEPTH))) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acq_start (acq_start),
    .wr_en     (wr_en),
    .wr_kind   (wr_kind),
    .wr_addr   (wr_addr),
    .wr_data_a (wr_data_a),
    .wr_data_b (wr_data_b)
);

// File: tb/acq_decim_bench.sv
// Bench for acq_decim: random and directed acquisitions compared entry by
// entry against a model of the expected memory writes.
module acq_decim_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 8192;
    localparam int MAXL       = 8;
    localparam int EXP_MAX    = 8400;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] adc_data = '0;
    logic        adc_chan = 1'b0;
    logic        acq_start = 1'b0;
    logic [1:0]  cfg_mode = '0;
    logic [3:0]  cfg_log2n = '0;
    logic        wr_en, wr_kind;
    logic [12:0] wr_addr;
    logic [13:0] wr_data_a, wr_data_b;

    int errors = 0;
    int checks = 0;
    int rd_idx = 0;
    int wr_idx = 0;
    bit done = 0;
    string cur_tag = "R11";

    logic [13:0] exp_a [EXP_MAX];
    logic [13:0] exp_b [EXP_MAX];
    logic        exp_k [EXP_MAX];
    logic [12:0] exp_ad [EXP_MAX];

    acq_decim u_acq_decim (
        .clk(clk), .rst_n(rst_n), .adc_data(adc_data), .adc_chan(adc_chan),
        .acq_start(acq_start), .cfg_mode(cfg_mode), .cfg_log2n(cfg_log2n),
        .wr_en(wr_en), .wr_kind(wr_kind), .wr_addr(wr_addr),
        .wr_data_a(wr_data_a), .wr_data_b(wr_data_b)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    // Compare every write against the next expected entry.
    always @(negedge clk) begin
        if (rst_n && wr_en && !done) begin
            if (rd_idx >= wr_idx) begin
                check(1'b0, cur_tag, "unexpected write at addr", longint'(wr_addr), 0);
            end else begin
                check(wr_data_a == exp_a[rd_idx] && wr_data_b == exp_b[rd_idx]
                      && wr_kind == exp_k[rd_idx] && wr_addr == exp_ad[rd_idx],
                      cur_tag, "write {kind,addr,a,b}",
                      {longint'(wr_kind), longint'(wr_addr), longint'(wr_data_a), longint'(wr_data_b)} ,
                      {longint'(exp_k[rd_idx]), longint'(exp_ad[rd_idx]),
                       longint'(exp_a[rd_idx]), longint'(exp_b[rd_idx])});
            end
            rd_idx++;
        end
    end

    task automatic push(input logic [13:0] a, input logic [13:0] b, input logic k);
        exp_a[wr_idx]  = a;
        exp_b[wr_idx]  = b;
        exp_k[wr_idx]  = k;
        exp_ad[wr_idx] = 13'(wr_idx % DEPTH);
        wr_idx++;
    endtask

    task automatic drive(input logic ch, input logic [13:0] d, input logic st);
        @(negedge clk);
        adc_chan  = ch;
        adc_data  = d;
        acq_start = st;
    endtask

    function automatic logic [13:0] gen(input int pat, input int i);
        case (pat)
            1:       return 14'h3FFF;
            2:       return (i % 2 == 0) ? 14'h0000 : 14'h3FFF;
            default: return 14'($urandom);
        endcase
    endfunction

    // Idle A words only: lets the pipeline empty without forming pairs.
    task automatic drain();
        repeat (6) drive(1'b0, 14'($urandom), 1'b0);
    endtask

    // One acquisition: full groups, an optional partial group, then drain.
    task automatic run_case(input int mode, input int l2n, input int groups,
                            input int partial, input int pat, input string tag);
        int em, s, g;
        bit first = 1;
        em = (mode == 3) ? 0 : mode;
        s  = (l2n > MAXL) ? MAXL : l2n;
        g  = (em == 2) ? (2 << s) : (1 << s);
        cur_tag = tag;
        rd_idx = 0;
        wr_idx = 0;
        cfg_mode  = 2'(mode);
        cfg_log2n = 4'(l2n);
        for (int grp = 0; grp < groups; grp++) begin
            longint sa = 0, sb = 0;
            logic [13:0] fa = 0, fb = 0, mna = 14'h3FFF, mnb = 14'h3FFF, mxa = 0, mxb = 0;
            for (int i = 0; i < g; i++) begin
                logic [13:0] a, b;
                a = gen(pat, i);
                b = gen(pat, i + 1);
                if (i == 0) begin fa = a; fb = b; end
                sa += a; sb += b;
                if (a < mna) mna = a;
                if (b < mnb) mnb = b;
                if (a > mxa) mxa = a;
                if (b > mxb) mxb = b;
                drive(1'b0, a, first);
                first = 0;
                if (i == g - 1) begin
                    if (em == 0) push(fa, fb, 1'b0);
                    else if (em == 1) push(14'(sa >> s), 14'(sb >> s), 1'b0);
                    else begin
                        push(mna, mnb, 1'b0);
                        push(mxa, mxb, 1'b1);
                    end
                end
                drive(1'b1, b, 1'b0);
            end
        end
        for (int i = 0; i < partial; i++) begin
            drive(1'b0, 14'($urandom), 1'b0);
            drive(1'b1, 14'($urandom), 1'b0);
        end
        drain();
        check(rd_idx == wr_idx, tag, "write count", rd_idx, wr_idx);
    endtask

    // Watchdog: a hung run ends as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'd4711);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(wr_en == 1'b0, "R1", "wr_en after reset", wr_en, 0);
        check(wr_addr == '0, "R1", "wr_addr after reset", wr_addr, 0);

        // R11: pairs before any start produce no write (monitor flags any).
        cur_tag = "R11";
        for (int i = 0; i < 10; i++) begin
            drive(1'b0, 14'($urandom), 1'b0);
            drive(1'b1, 14'($urandom), 1'b0);
        end
        drain();
        check(rd_idx == 0, "R11", "writes before first start", rd_idx, 0);

        // R9 latency and R3 data, decimate with N = 1.
        begin
            logic [13:0] a1, b1, a2, b2;
            a1 = 14'h0123; b1 = 14'h2345; a2 = 14'h1111; b2 = 14'h3210;
            cur_tag = "R9";
            rd_idx = 0; wr_idx = 0;
            cfg_mode = 2'd0; cfg_log2n = 4'd0;
            push(a1, b1, 1'b0);
            push(a2, b2, 1'b0);
            drive(1'b0, a1, 1'b1);
            drive(1'b1, b1, 1'b0);
            drive(1'b0, a2, 1'b0);
            drive(1'b1, b2, 1'b0);
            check(wr_en == 1'b0, "R9", "wr_en one cycle early", wr_en, 0);
            drive(1'b0, 14'h0, 1'b0);
            check(wr_en == 1'b1 && wr_data_a == a1, "R9", "first write timing/data",
                  {wr_en, wr_data_a}, {1'b1, a1});
            drain();
            check(rd_idx == wr_idx, "R9", "write count", rd_idx, wr_idx);
        end

        // R2: repeated A words, the latest one pairs with the next B.
        cur_tag = "R2";
        rd_idx = 0; wr_idx = 0;
        cfg_mode = 2'd0; cfg_log2n = 4'd0;
        push(14'h0AAA, 14'h0BBB, 1'b0);
        drive(1'b0, 14'h1000, 1'b1);
        drive(1'b0, 14'h2000, 1'b0);
        drive(1'b0, 14'h0AAA, 1'b0);
        drive(1'b1, 14'h0BBB, 1'b0);
        drain();
        check(rd_idx == wr_idx, "R2", "write count", rd_idx, wr_idx);

        // R6: N = 1 in each mode.
        run_case(0, 0, 5, 0, 0, "R6");
        run_case(1, 0, 5, 0, 0, "R6");
        run_case(2, 0, 5, 0, 0, "R6");
        // R4: full-scale average at the largest N.
        run_case(1, 8, 2, 0, 1, "R4");
        run_case(1, 3, 4, 0, 2, "R4");
        // R5: min/max with alternating extremes.
        run_case(2, 2, 3, 0, 2, "R5");
        // R7: partial group dropped at the restart that follows.
        run_case(1, 2, 2, 3, 0, "R7");
        run_case(2, 1, 1, 3, 0, "R7");
        // R10: mode code 3 and a shift above the maximum.
        run_case(3, 2, 3, 0, 0, "R10");
        run_case(2, 15, 1, 0, 0, "R10");
        // R3 / R4 / R5 random configurations.
        for (int t = 0; t < 24; t++) begin
            int m, l;
            m = int'($urandom % 3);
            l = int'($urandom % 5);
            run_case(m, l, 1 + int'($urandom % 5), int'($urandom % 3) % ((m == 2 ? 2 : 1) << l),
                     0, (m == 0) ? "R3" : (m == 1) ? "R4" : "R5");
        end
        // R8: address wrap past the memory depth.
        run_case(0, 0, DEPTH + 4, 0, 0, "R8");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule